// File: doc/BRIEF.md
# BCH(15,7) Double-Error Syndrome-Table Decoder

This block corrects up to two bit errors in 15-bit words of a binary cyclic BCH code that carries 7 information bits and 8 check bits and has minimum distance 5. The generator polynomial is g(x) = x^8 + x^7 + x^6 + x^4 + 1 (binary 1_1101_0001). The remainder of the received word divided by g(x) over GF(2) is the 8-bit syndrome. The syndrome addresses a 256-entry table of error patterns, and the selected pattern is XORed onto the received word.

The table is not loaded from outside. After reset, a sequencer walks through every single and double bit position. It computes the syndrome of each pattern and writes the pattern at that address. The table marks every address it never writes as uncorrectable. The `ready` output stays low until all 120 patterns are stored, and words offered before then are dropped.

Once ready, the decoder accepts one word per clock on `in_valid`. It returns the result two clocks later on `out_valid`, together with the 7 information bits and an uncorrectable flag.

Top module: `bch15_table_decoder`

## Requirements
- R1: The syndrome is the remainder of the received word (coefficient of x^14 at bit 14) divided by g(x) = x^8+x^7+x^6+x^4+1 over GF(2). A received word whose syndrome is zero is output unchanged with `out_uncorrectable` = 0.
- R2: Any single-bit error on a codeword is corrected. The output equals the transmitted codeword and `out_uncorrectable` = 0.
- R3: Any two-bit error on a codeword is corrected. The output equals the transmitted codeword and `out_uncorrectable` = 0.
- R4: When the syndrome equals the syndrome of no pattern of weight 0, 1 or 2, `out_uncorrectable` = 1 and `out_word` equals the received word.
- R5: When a received word with more than two errors has a syndrome that equals the syndrome of some weight-1 or weight-2 pattern e, the output is the received word XOR e with `out_uncorrectable` = 0. That output is a codeword.
- R6: The code is systematic. `out_info` equals bits 14..8 of `out_word`, and bits 7..0 hold the check bits.
- R7: A word accepted at a rising edge (`in_valid` and `ready` both high) is presented with `out_valid` high after the second following rising edge. Back-to-back words are accepted every clock and leave in order.
- R8: While `rst_n` is sampled low, `out_valid` and `ready` are 0 after the edge.
- R9: `ready` goes high exactly 120 clocks after the first edge that samples `rst_n` high. It then stays high until the next reset.
- R10: A word presented with `in_valid` high while `ready` is low is ignored. It produces no `out_valid`.
- R11: No two patterns of weight 1 or 2 share a syndrome, and no such pattern has a zero syndrome. The fill therefore never writes an address twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| ready | output | 1 | High once the error-pattern table is filled |
| in_valid | input | 1 | Received word present on `in_word` |
| in_word | input | 15 | Received word, bit 14 = coefficient of x^14 |
| out_valid | output | 1 | Decoded result present |
| out_word | output | 15 | Corrected (or passed-through) word |
| out_info | output | 7 | Information bits, bits 14..8 of `out_word` |
| out_uncorrectable | output | 1 | Syndrome matched no stored pattern |

## Verification
On every cycle, the assertions check the following:
- every non-flagged output is a codeword within distance two of the input taken two clocks before;
- every flagged output equals that input;
- `out_valid` follows accepted input with exactly two clocks of delay;
- `ready` never falls outside reset;
- the fill never writes an address twice or writes address zero.

The bench scenarios show the rest:
- the syndrome-to-correction mapping produces the transmitted codeword for known messages;
- `ready` rises on the exact 120th clock;
- words offered during the fill are dropped;
- words with three errors split correctly into miscorrected and flagged cases.

// File: rtl/bch15_pkg.sv
// Package: code constants and a GF(2) remainder helper shared by the
// decoder modules and their assertions.
// Assumes: systematic layout, bit 14 is the x^14 coefficient.
package bch15_pkg;

    localparam int CW_N   = 15;                  // codeword length
    localparam int CHK_R  = 8;                   // check bits
    localparam int INFO_K = CW_N - CHK_R;        // information bits
    localparam logic [CHK_R:0] GEN_POLY = 9'b1_1101_0001;   // x^8+x^7+x^6+x^4+1

    // Remainder of w divided by GEN_POLY over GF(2).
    function automatic logic [CHK_R-1:0] gf2_rem(input logic [CW_N-1:0] w);
        logic [CW_N-1:0] r;
        logic [CW_N-1:0] g_ext;
        g_ext = CW_N'(GEN_POLY);
        r = w;
        for (int p = CW_N - 1; p >= CHK_R; p--) begin
            if (r[p]) r = r ^ (g_ext << (p - CHK_R));
        end
        return r[CHK_R-1:0];
    endfunction

endpackage

// File: rtl/bch15_syndrome.sv
// Module: combinational polynomial divider. It produces the remainder of
// an N-bit word divided by the (R+1)-bit generator GEN over GF(2).
// Assumes: GEN has its top bit (x^R) set; the word MSB is the highest power.
module bch15_syndrome #(
    parameter int N = bch15_pkg::CW_N,
    parameter int R = bch15_pkg::CHK_R,
    parameter logic [R:0] GEN = bch15_pkg::GEN_POLY
) (
    input  logic [N-1:0] word,
    output logic [R-1:0] syndrome
);

    localparam logic [N-1:0] GEN_EXT = N'(GEN);

    // Long division: clear each leading coefficient from the top down.
    always_comb begin
        logic [N-1:0] rem;
        rem = word;
        for (int p = N - 1; p >= R; p--) begin
            if (rem[p]) rem = rem ^ (GEN_EXT << (p - R));
        end
        syndrome = rem[R-1:0];
    end

endmodule

// File: rtl/bch15_pattern_fill.sv
// Module: table fill sequencer. After reset it visits every pair of bit
// positions (a, b) with a <= b < N, one per clock. a == b gives a single
// error and a < b gives a double error. For each pair it presents the
// pattern and the pattern's syndrome as a write. N(N+1)/2 writes are
// issued, then done rises and stays high.
// Assumes: synchronous active-low reset restarts the walk.
module bch15_pattern_fill #(
    parameter int N = bch15_pkg::CW_N,
    parameter int R = bch15_pkg::CHK_R,
    parameter logic [R:0] GEN = bch15_pkg::GEN_POLY
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic         wr_en,
    output logic [R-1:0] wr_addr,
    output logic [N-1:0] wr_pattern,
    output logic         done
);

    localparam int PW = $clog2(N);
    localparam logic [PW-1:0] LAST = PW'(N - 1);

    logic [PW-1:0] pos_a;
    logic [PW-1:0] pos_b;
    logic          busy;

    // Walk (a, b) in order; when b reaches the end, advance a and restart b at a.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_a <= '0;
            pos_b <= '0;
            busy  <= 1'b1;
            done  <= 1'b0;
        end else if (busy) begin
            if (pos_b == LAST) begin
                if (pos_a == LAST) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    pos_a <= pos_a + 1'b1;
                    pos_b <= pos_a + 1'b1;
                end
            end else begin
                pos_b <= pos_b + 1'b1;
            end
        end
    end

    // Pattern with ones at positions a and b (a single one when a == b).
    always_comb begin
        wr_pattern = (N'(1) << pos_a) | (N'(1) << pos_b);
    end

    assign wr_en = busy;

    bch15_syndrome #(.N(N), .R(R), .GEN(GEN)) u_pat_syn (
        .word     (wr_pattern),
        .syndrome (wr_addr)
    );

    // R11
    fill_nonzero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr != '0));

    // R9
    fill_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !wr_en);

endmodule

// File: rtl/bch15_err_table.sv
// Module: syndrome-addressed error-pattern store. Each of the 2^R entries
// has a hit flag and an N-bit pattern. Reset clears every hit flag except
// entry zero, which is hard-wired to the all-zero (no error) pattern. A
// write sets the hit flag and stores the pattern. The read is
// combinational.
// Assumes: the writer never targets address zero.
module bch15_err_table #(
    parameter int N = bch15_pkg::CW_N,
    parameter int R = bch15_pkg::CHK_R
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [R-1:0] wr_addr,
    input  logic [N-1:0] wr_pattern,
    input  logic [R-1:0] rd_addr,
    output logic         rd_hit,
    output logic [N-1:0] rd_pattern
);

    localparam int DEPTH = 1 << R;

    logic [DEPTH-1:0] hit_mem;
    logic [N-1:0]     pat_mem [DEPTH];

    // Hit flags: reset marks only the zero syndrome as correctable.
    always_ff @(posedge clk) begin
        if (!rst_n)     hit_mem <= DEPTH'(1);
        else if (wr_en) hit_mem[wr_addr] <= 1'b1;
    end

    // Pattern storage: plain write port, no reset needed behind the hit flags.
    always_ff @(posedge clk) begin
        if (wr_en) pat_mem[wr_addr] <= wr_pattern;
    end

    // Read: entry zero always returns the empty pattern.
    always_comb begin
        rd_hit     = hit_mem[rd_addr];
        rd_pattern = (rd_addr == '0) ? '0 : pat_mem[rd_addr];
    end

    // R11
    no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !hit_mem[wr_addr]);

endmodule

// File: rtl/bch15_table_decoder.sv
// Module: top of the BCH(15,7) double-error decoder.
//   Stage 1 registers the accepted word and its syndrome.
//   Stage 2 looks the syndrome up in the pattern table and registers the
//   corrected word, or the received word with the flag set.
// Words are taken only when ready is high, which happens once the fill
// sequencer has stored every weight-1 and weight-2 pattern.
// Assumes: synchronous active-low reset; at most one word per clock.
module bch15_table_decoder #(
    parameter int N = bch15_pkg::CW_N,
    parameter int R = bch15_pkg::CHK_R,
    parameter logic [R:0] GEN = bch15_pkg::GEN_POLY,
    localparam int K = N - R
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic         ready,
    input  logic         in_valid,
    input  logic [N-1:0] in_word,
    output logic         out_valid,
    output logic [N-1:0] out_word,
    output logic [K-1:0] out_info,
    output logic         out_uncorrectable
);

    logic         fill_wr_en;
    logic [R-1:0] fill_addr;
    logic [N-1:0] fill_pattern;
    logic         fill_done;

    logic [R-1:0] in_syn;
    logic         s1_valid;
    logic [N-1:0] s1_word;
    logic [R-1:0] s1_syn;
    logic         tbl_hit;
    logic [N-1:0] tbl_pattern;
    logic         accept;

    bch15_pattern_fill #(.N(N), .R(R), .GEN(GEN)) u_fill (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (fill_wr_en),
        .wr_addr    (fill_addr),
        .wr_pattern (fill_pattern),
        .done       (fill_done)
    );

    bch15_err_table #(.N(N), .R(R)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (fill_wr_en),
        .wr_addr    (fill_addr),
        .wr_pattern (fill_pattern),
        .rd_addr    (s1_syn),
        .rd_hit     (tbl_hit),
        .rd_pattern (tbl_pattern)
    );

    bch15_syndrome #(.N(N), .R(R), .GEN(GEN)) u_in_syn (
        .word     (in_word),
        .syndrome (in_syn)
    );

    assign ready  = fill_done;
    assign accept = in_valid && fill_done;

    // Stage 1: capture the accepted word and its syndrome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_word  <= '0;
            s1_syn   <= '0;
        end else begin
            s1_valid <= accept;
            if (accept) begin
                s1_word <= in_word;
                s1_syn  <= in_syn;
            end
        end
    end

    // Stage 2: apply the table pattern, or pass through and flag on a miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid         <= 1'b0;
            out_word          <= '0;
            out_uncorrectable <= 1'b0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_word          <= tbl_hit ? (s1_word ^ tbl_pattern) : s1_word;
                out_uncorrectable <= !tbl_hit;
            end
        end
    end

    assign out_info = out_word[N-1:R];

    // R7
    lat_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid && ready, 2));

    // R7
    lat_bwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && ready, 2) |-> out_valid);

    // R9
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    // R10
    idle_until_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !out_valid);

    // R4
    flag_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_uncorrectable) |-> (out_word == $past(in_word, 2)));

    // R5
    fix_is_codeword_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_uncorrectable) |-> (bch15_pkg::gf2_rem(out_word) == '0));

    // R3
    fix_distance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_uncorrectable) |-> ($countones(out_word ^ $past(in_word, 2)) <= 2));

endmodule

// File: tb/bch15_table_decoder_bench.sv
`timescale 1ns/1ps
// Bench: reset and fill timing, dropped input while filling, directed
// corner words, then a constrained random stream of codewords with 0..3
// injected errors. A reference model checks the results, then a second
// reset is applied.
module bch15_table_decoder_bench;

    localparam int N = 15;
    localparam int R = 8;
    localparam int K = 7;
    localparam int FILL_CYCLES = N * (N + 1) / 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ready;
    logic         in_valid = 1'b0;
    logic [N-1:0] in_word = '0;
    logic         out_valid;
    logic [N-1:0] out_word;
    logic [K-1:0] out_info;
    logic         out_uncorrectable;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int seen_unc = 0;
    int seen_mis = 0;

    logic [N-1:0] q_word [$];
    logic         q_unc  [$];
    int           q_stamp[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    bch15_table_decoder u_bch15_table_decoder (
        .clk               (clk),
        .rst_n             (rst_n),
        .ready             (ready),
        .in_valid          (in_valid),
        .in_word           (in_word),
        .out_valid         (out_valid),
        .out_word          (out_word),
        .out_info          (out_info),
        .out_uncorrectable (out_uncorrectable)
    );

    // Reference remainder modulo x^8+x^7+x^6+x^4+1.
    function automatic logic [R-1:0] ref_rem(input logic [N-1:0] w);
        logic [N-1:0] r = w;
        for (int p = N - 1; p >= R; p--)
            if (r[p]) r ^= (15'b000_0001_1101_0001 << (p - R));
        return r[R-1:0];
    endfunction

    function automatic logic [N-1:0] ref_encode(input logic [K-1:0] info);
        logic [N-1:0] sh = {info, 8'h00};
        return sh | N'(ref_rem(sh));
    endfunction

    // Reference decode by exhaustive search over weight-1/2 patterns.
    task automatic ref_decode(input logic [N-1:0] w, output logic [N-1:0] ew, output logic eu);
        logic [R-1:0] s = ref_rem(w);
        ew = w; eu = 1'b0;
        if (s == '0) return;
        for (int a = 0; a < N; a++)
            for (int b = a; b < N; b++) begin
                logic [N-1:0] e = (N'(1) << a) | (N'(1) << b);
                if (ref_rem(e) == s) begin ew = w ^ e; return; end
            end
        eu = 1'b1;
    endtask

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Offer one word for one clock; queue the expectation if it will be taken.
    task automatic send(input logic [N-1:0] w, input string req);
        logic [N-1:0] ew;
        logic eu;
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        if (ready) begin
            ref_decode(w, ew, eu);
            q_word.push_back(ew);
            q_unc.push_back(eu);
            q_stamp.push_back(cyc + 1);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    function automatic logic [N-1:0] add_errors(input logic [N-1:0] cw, input int wt);
        logic [N-1:0] e = '0;
        while ($countones(e) < wt) e[$urandom_range(N - 1, 0)] = 1'b1;
        return cw ^ e;
    endfunction

    // Scoreboard: compare every result against the queued expectation (R4, R5, R6, R7, R10).
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (q_word.size() == 0) begin
                check(1'b0, "R10", "unexpected out_valid", 1, 0);
            end else begin
                logic [N-1:0] ew;
                logic eu;
                int st;
                ew = q_word.pop_front();
                eu = q_unc.pop_front();
                st = q_stamp.pop_front();
                check(out_word == ew, "R2/R3/R4/R5", "out_word", out_word, ew);
                check(out_uncorrectable == eu, "R4", "out_uncorrectable", out_uncorrectable, eu);
                check(out_info == out_word[N-1:R], "R6", "out_info", out_info, out_word[N-1:R]);
                check(cyc == st + 1, "R7", "latency edge", cyc, st + 1);
                if (eu) seen_unc++;
                else if ($countones(out_word ^ in_word) > 0 && ref_rem(out_word) == '0 && ew != out_word) seen_mis++;
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(8 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int k;
        logic [K-1:0] info;
        logic [N-1:0] cw;
        void'($urandom(32'd20190046));

        // R8: reset state.
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R8", "out_valid in reset", out_valid, 0);
        check(ready == 1'b0, "R8", "ready in reset", ready, 0);

        // R9 and R10: release reset, offer words while filling, count clocks to ready.
        rst_n = 1'b1;
        k = 0;
        while (!ready && k < 400) begin
            send(ref_encode(K'(k)), "R10");
            k++;
        end
        check(k == FILL_CYCLES, "R9", "clocks to ready", k, FILL_CYCLES);
        idle(3);
        check(q_word.size() == 0, "R10", "words accepted while filling", q_word.size(), 0);

        // R1 and R6: known codeword (info 0000001 is the generator itself).
        check(ref_encode(7'h01) == 15'h01D1, "R6", "reference encoder", ref_encode(7'h01), 15'h01D1);
        send(15'h01D1, "R1");
        send(15'h01D1 ^ 15'h0008, "R2");          // single error at bit 3
        send(15'h01D1 ^ 15'h4001, "R3");          // double error at both ends
        send(15'h0000, "R1");
        send(ref_encode(7'h7F), "R1");
        send(ref_encode(7'h7F) ^ 15'h4000, "R2");
        send(ref_encode(7'h55) ^ 15'h0003, "R3");
        idle(4);

        // Directed: every single error on one codeword, back to back (R2, R7).
        cw = ref_encode(7'h2A);
        for (int p = 0; p < N; p++) send(cw ^ (N'(1) << p), "R2");
        idle(4);

        // Random stream of 0..3 errors with occasional gaps (R2, R3, R4, R5, R7).
        for (int i = 0; i < 1500; i++) begin
            info = K'($urandom);
            send(add_errors(ref_encode(info), $urandom_range(3, 0)), "R5");
            if ($urandom_range(7, 0) == 0) idle(1);
        end
        idle(5);
        check(seen_unc > 0, "R4", "uncorrectable cases seen", seen_unc, 1);
        check(q_word.size() == 0, "R7", "queue drained", q_word.size(), 0);

        // R8 and R9: reset mid-run clears the outputs and refills the table.
        send(ref_encode(7'h11), "R8");
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R8", "out_valid after reset", out_valid, 0);
        check(ready == 1'b0, "R8", "ready after reset", ready, 0);
        q_word.delete(); q_unc.delete(); q_stamp.delete();
        @(negedge clk);
        rst_n = 1'b1;
        k = 0;
        while (!ready && k < 400) begin @(negedge clk); k++; end
        check(k == FILL_CYCLES, "R9", "clocks to ready after re-reset", k, FILL_CYCLES);
        send(ref_encode(7'h33) ^ 15'h0410, "R3");
        idle(4);
        check(q_word.size() == 0, "R7", "final word returned", q_word.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule